// File: doc/BRIEF.md
# Serial EPROM Command Sequencer

This block is the device-side controller of a 1024-bit one-time-programmable memory behind a byte-wide serial command link. An outer layer turns single-wire bit slots into whole bytes, least significant bit first. It gives this block each received byte as a one-cycle strobe and pulls response bytes one at a time. The sequencer decodes a read command and a write command. It captures a 16-bit start address and returns 8-bit CRCs. A read streams memory to its end. A write stages eight bytes and, once a confirm byte arrives and the programming supply has stayed present long enough, ANDs them into one aligned segment.

The array comes out of reset fully erased (every bit 1). Programming can only clear bits. The host checks each CRC itself and pulses the bus-reset input if it sees a mismatch. The sequencer never aborts because of a CRC. A bus reset returns the sequencer to idle from any state except the programming pulse. During the pulse, a bus reset is ignored and the commit completes.

Top module: `otp_link_seq`

## Requirements
- R1: After reset no response byte is offered (`tx_vld_o` low), `prog_o` is low, and every one of the 128 memory bytes reads FFh.
- R2: Command F0h followed by address low byte and high byte (address below 128) offers a CRC over those three bytes. Each `tx_rd_i` then yields memory bytes from the start address upward, through byte 127. After byte 127 no response is offered. An offered byte stays stable until it is pulled.
- R3: Command 0Fh followed by address low and high bytes (address a multiple of 8 below 128) offers one CRC byte over those three bytes. The CRC uses the polynomial x^8+x^5+x^4+1, shifted LSB first with the reflected constant 8Ch, with the register cleared at the start of each span.
- R4: After the header CRC is pulled, exactly eight received bytes are staged. A second CRC is then offered, computed over those eight bytes alone.
- R5: After the data CRC is pulled, a confirm byte 5Ah followed by `vpp_i` held high for PROG_CYC consecutive cycles makes each byte of the addressed segment equal to its old value ANDed with the staged byte. Bits are never set.
- R6: Right after the commit, the eight bytes of the segment are offered in ascending order from the start address. After the eighth byte no response is offered.
- R7: A write address that is unaligned or not below 128 (including any nonzero high byte), a read address not below 128, or an unknown command byte leaves the block silent until a bus reset. In that case memory does not change.
- R8: A confirm byte other than 5Ah leaves the block silent. No pulse starts and memory does not change, whatever `vpp_i` does afterwards.
- R9: `bus_rst_i` returns the sequencer to idle from any state except the pulse. A bus reset during the pulse is ignored and the commit still happens.
- R10: If `vpp_i` drops before the pulse completes, memory does not change and the block stays silent until a bus reset.
- R11: `prog_o` is high exactly while the pulse runs: from the cycle after `vpp_i` is seen in the armed state until the commit. It is never high together with `tx_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rst_i | input | 1 | One-cycle strobe: reset pulse seen on the serial link |
| rx_vld_i | input | 1 | One-cycle strobe: a received byte is on `rx_byte_i` |
| rx_byte_i | input | 8 | Received byte |
| tx_rd_i | input | 1 | Strobe: the outer layer takes the offered response byte |
| tx_vld_o | output | 1 | A response byte is offered |
| tx_byte_o | output | 8 | Offered response byte |
| vpp_i | input | 1 | Programming supply present |
| prog_o | output | 1 | Programming pulse in progress |

## Verification
The hardest case to reach from the ports is a bus reset that arrives while the programming pulse is running. It must be ignored, and the commit must still land with the correct AND of old and staged data. The bench reaches it by running complete write flows to randomly chosen segments. It raises the bus reset on the first pulse cycle, then reads the segment back. It also rewrites a segment that was already programmed, so that the AND is visible rather than a plain overwrite. Separate directed flows drop `vpp_i` halfway, send a wrong confirm byte and abort during staging. Full-memory reads then show that none of these touched the array.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

  localparam logic [7:0] CMD_READ  = 8'hF0;
  localparam logic [7:0] CMD_WRITE = 8'h0F;
  localparam logic [7:0] CONFIRM_B = 8'h5A;
  localparam logic [7:0] CRC_POLY  = 8'h8C;  // reflected x^8+x^5+x^4+1

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_LO,
    ST_ADR_HI,
    ST_HDR_CRC,
    ST_DATA,
    ST_DAT_CRC,
    ST_CONFIRM,
    ST_VPP_WAIT,
    ST_PULSE,
    ST_VERIFY,
    ST_STREAM,
    ST_HALT
  } seq_st_e;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] c;
    logic       mix;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      mix = c[0] ^ din[i];
      c   = c >> 1;
      if (mix) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/otp_crc8.sv
module otp_crc8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [7:0] din_i,
  output logic [7:0] crc_o
);
  import otp_seq_pkg::*;

  logic [7:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (en_i) crc_d = crc8_step(clr_i ? 8'h00 : crc_q, din_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 8'h00;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/otp_stage_buf.sv
module otp_stage_buf #(
  parameter int SEG_BYTES = 8,
  localparam int IW = $clog2(SEG_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [IW-1:0]          idx_i,
  input  logic [7:0]             din_i,
  output logic [SEG_BYTES*8-1:0] stage_o
);
  for (genvar j = 0; j < SEG_BYTES; j++) begin : g_lane
    logic [7:0] lane_q;
    logic       lane_en;
    assign lane_en = we_i && (idx_i == IW'(j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= 8'hFF;
      else if (lane_en) lane_q <= din_i;
    end
    assign stage_o[j*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int MEM_BYTES = 128,
  parameter int SEG_BYTES = 8,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int IW = $clog2(SEG_BYTES),
  localparam int SW = AW - IW
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prog_i,
  input  logic [SW-1:0]          seg_i,
  input  logic [SEG_BYTES*8-1:0] stage_i,
  input  logic [AW-1:0]          rd_addr_i,
  output logic [7:0]             rd_data_o
);
  logic [MEM_BYTES*8-1:0] flat;

  for (genvar k = 0; k < MEM_BYTES; k++) begin : g_cell
    logic [7:0] cell_q;
    logic       hit;
    assign hit = prog_i && (seg_i == SW'(k / SEG_BYTES));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q <= 8'hFF;
      else if (hit) cell_q <= cell_q & stage_i[(k % SEG_BYTES)*8 +: 8];
    end
    assign flat[k*8 +: 8] = cell_q;
  end

  assign rd_data_o = flat[rd_addr_i*8 +: 8];
endmodule

// File: rtl/otp_link_seq.sv
module otp_link_seq #(
  parameter int MEM_BYTES = 128,
  parameter int SEG_BYTES = 8,
  parameter int PROG_CYC  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst_i,
  input  logic       rx_vld_i,
  input  logic [7:0] rx_byte_i,
  input  logic       tx_rd_i,
  output logic       tx_vld_o,
  output logic [7:0] tx_byte_o,
  input  logic       vpp_i,
  output logic       prog_o
);
  import otp_seq_pkg::*;

  localparam int AW  = $clog2(MEM_BYTES);
  localparam int IW  = $clog2(SEG_BYTES);
  localparam int SW  = AW - IW;
  localparam int PCW = $clog2(PROG_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  seq_st_e        st_q, st_d;
  logic [7:0]     adr_lo_q, adr_lo_d;
  logic [AW-1:0]  ptr_q, ptr_d;
  logic [IW-1:0]  idx_q, idx_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           wr_q, wr_d;

  logic       crc_en, crc_clr, stg_we, prog_we;
  logic [7:0] crc_val, rd_data;
  logic [SEG_BYTES*8-1:0] stage;
  logic       in_range, aligned;

  assign in_range = ({rx_byte_i, adr_lo_q} < 16'(MEM_BYTES));
  assign aligned  = (adr_lo_q[IW-1:0] == '0);

  always_comb begin
    st_d     = st_q;
    adr_lo_d = adr_lo_q;
    ptr_d    = ptr_q;
    idx_d    = idx_q;
    pcnt_d   = pcnt_q;
    wr_d     = wr_q;
    crc_en   = 1'b0;
    crc_clr  = 1'b0;
    stg_we   = 1'b0;
    prog_we  = 1'b0;
    case (st_q)
      ST_IDLE: if (rx_vld_i) begin
        crc_en  = 1'b1;
        crc_clr = 1'b1;
        if (rx_byte_i == CMD_READ) begin
          wr_d = 1'b0;
          st_d = ST_ADR_LO;
        end else if (rx_byte_i == CMD_WRITE) begin
          wr_d = 1'b1;
          st_d = ST_ADR_LO;
        end else begin
          st_d = ST_HALT;
        end
      end
      ST_ADR_LO: if (rx_vld_i) begin
        crc_en   = 1'b1;
        adr_lo_d = rx_byte_i;
        st_d     = ST_ADR_HI;
      end
      ST_ADR_HI: if (rx_vld_i) begin
        crc_en = 1'b1;
        if (!in_range || (wr_q && !aligned)) begin
          st_d = ST_HALT;
        end else begin
          ptr_d = adr_lo_q[AW-1:0];
          st_d  = ST_HDR_CRC;
        end
      end
      ST_HDR_CRC: if (tx_rd_i) begin
        idx_d = '0;
        st_d  = wr_q ? ST_DATA : ST_STREAM;
      end
      ST_DATA: if (rx_vld_i) begin
        crc_en  = 1'b1;
        crc_clr = (idx_q == '0);
        stg_we  = 1'b1;
        if (idx_q == IW'(SEG_BYTES - 1)) st_d = ST_DAT_CRC;
        else                             idx_d = idx_q + 1'b1;
      end
      ST_DAT_CRC: if (tx_rd_i) st_d = ST_CONFIRM;
      ST_CONFIRM: if (rx_vld_i) st_d = (rx_byte_i == CONFIRM_B) ? ST_VPP_WAIT : ST_HALT;
      ST_VPP_WAIT: if (vpp_i) begin
        pcnt_d = '0;
        st_d   = ST_PULSE;
      end
      ST_PULSE: begin
        if (!vpp_i) begin
          st_d = ST_HALT;
        end else if (pcnt_q == PCW'(PROG_CYC - 1)) begin
          prog_we = 1'b1;
          idx_d   = '0;
          st_d    = ST_VERIFY;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
        end
      end
      ST_VERIFY: if (tx_rd_i) begin
        if (idx_q == IW'(SEG_BYTES - 1)) begin
          st_d = ST_HALT;
        end else begin
          idx_d = idx_q + 1'b1;
          ptr_d = ptr_q + 1'b1;
        end
      end
      ST_STREAM: if (tx_rd_i) begin
        if (ptr_q == AW'(MEM_BYTES - 1)) st_d = ST_HALT;
        else                             ptr_d = ptr_q + 1'b1;
      end
      default: st_d = st_q;
    endcase
    if (bus_rst_i && st_q != ST_PULSE) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q     <= ST_IDLE;
      adr_lo_q <= 8'h00;
      ptr_q    <= '0;
      idx_q    <= '0;
      pcnt_q   <= '0;
      wr_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      adr_lo_q <= adr_lo_d;
      ptr_q    <= ptr_d;
      idx_q    <= idx_d;
      pcnt_q   <= pcnt_d;
      wr_q     <= wr_d;
    end
  end

  otp_crc8 u_crc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (crc_en),
    .clr_i (crc_clr),
    .din_i (rx_byte_i),
    .crc_o (crc_val)
  );

  otp_stage_buf #(.SEG_BYTES(SEG_BYTES)) u_stage (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (stg_we),
    .idx_i   (idx_q),
    .din_i   (rx_byte_i),
    .stage_o (stage)
  );

  otp_cell_array #(.MEM_BYTES(MEM_BYTES), .SEG_BYTES(SEG_BYTES)) u_array (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .prog_i    (prog_we),
    .seg_i     (ptr_q[AW-1:IW]),
    .stage_i   (stage),
    .rd_addr_i (ptr_q),
    .rd_data_o (rd_data)
  );

  always_comb begin
    tx_vld_o  = 1'b0;
    tx_byte_o = rd_data;
    case (st_q)
      ST_HDR_CRC, ST_DAT_CRC: begin
        tx_vld_o  = 1'b1;
        tx_byte_o = crc_val;
      end
      ST_VERIFY, ST_STREAM: tx_vld_o = 1'b1;
      default: tx_vld_o = 1'b0;
    endcase
  end

  assign prog_o = (st_q == ST_PULSE);
endmodule

// File: rtl/otp_link_seq_chk.sv
module otp_link_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rst_i,
  input logic       vpp_i,
  input logic       tx_rd_i,
  input logic       tx_vld_o,
  input logic [7:0] tx_byte_o,
  input logic       prog_o,
  input logic       commit,
  input logic       halted
);
  AST_RST_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i && !prog_o |=> !tx_vld_o && !prog_o);  // R9
  AST_PULSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o && vpp_i && bus_rst_i |=> prog_o || tx_vld_o);  // R9
  AST_VPP_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o && !vpp_i |=> !prog_o && !tx_vld_o && halted);  // R10
  AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> prog_o && vpp_i);  // R5
  AST_COMMIT_THEN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> tx_vld_o && !prog_o);  // R6
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !tx_vld_o && !prog_o);  // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld_o && !tx_rd_i && !bus_rst_i |=> tx_vld_o && $stable(tx_byte_o));  // R2
  AST_PROG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_o, tx_vld_o}));  // R11
endmodule

bind otp_link_seq otp_link_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_rst_i (bus_rst_i),
  .vpp_i     (vpp_i),
  .tx_rd_i   (tx_rd_i),
  .tx_vld_o  (tx_vld_o),
  .tx_byte_o (tx_byte_o),
  .prog_o    (prog_o),
  .commit    (prog_we),
  .halted    (st_q == otp_seq_pkg::ST_HALT)
);

// File: tb/otp_link_seq_tb_top.sv
module otp_link_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int NB    = 128;
  localparam int SB    = 8;
  localparam int PROG  = 24;

  logic       clk;
  logic       rst_n;
  logic       bus_rst_i;
  logic       rx_vld_i;
  logic [7:0] rx_byte_i;
  logic       tx_rd_i;
  logic       tx_vld_o;
  logic [7:0] tx_byte_o;
  logic       vpp_i;
  logic       prog_o;

  int n_chk;
  int n_err;
  logic [7:0] exp_mem [NB];

  otp_link_seq #(.MEM_BYTES(NB), .SEG_BYTES(SB), .PROG_CYC(PROG)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rst_i (bus_rst_i),
    .rx_vld_i  (rx_vld_i),
    .rx_byte_i (rx_byte_i),
    .tx_rd_i   (tx_rd_i),
    .tx_vld_o  (tx_vld_o),
    .tx_byte_o (tx_byte_o),
    .vpp_i     (vpp_i),
    .prog_o    (prog_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 8'h8C;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] crc3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    return crc_upd(crc_upd(crc_upd(8'h00, a), b), c);
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte_i = b;
    rx_vld_i  = 1'b1;
    @(negedge clk);
    rx_vld_i  = 1'b0;
  endtask

  task automatic take(input string tag, input logic [7:0] exp);
    chk({tag, " valid"}, int'(tx_vld_o), 1);
    chk(tag, int'(tx_byte_o), int'(exp));
    tx_rd_i = 1'b1;
    @(negedge clk);
    tx_rd_i = 1'b0;
  endtask

  task automatic bus_reset();
    bus_rst_i = 1'b1;
    @(negedge clk);
    bus_rst_i = 1'b0;
  endtask

  // full read from 0: checks header CRC, all bytes against the model, and end of stream
  task automatic read_all(input string tag);
    send(8'hF0); send(8'h00); send(8'h00);
    take({tag, " R2 crc"}, crc3(8'hF0, 8'h00, 8'h00));
    for (int a = 0; a < NB; a++) take({tag, " R2 data"}, exp_mem[a]);
    chk({tag, " R2 end silent"}, int'(tx_vld_o), 0);
    bus_reset();
  endtask

  // header plus eight data bytes, ends in the confirm-waiting state
  task automatic stage_seg(input int seg, input logic [7:0] d [SB]);
    logic [7:0] c;
    send(8'h0F); send(8'(seg*SB)); send(8'h00);
    take("R3 header crc", crc3(8'h0F, 8'(seg*SB), 8'h00));
    c = 8'h00;
    for (int i = 0; i < SB; i++) begin
      send(d[i]);
      c = crc_upd(c, d[i]);
    end
    take("R4 data crc", c);
  endtask

  task automatic write_seg(input int seg, input logic [7:0] d [SB], input bit mid_rst);
    stage_seg(seg, d);
    send(8'h5A);
    vpp_i = 1'b1;
    @(negedge clk);
    chk("R11 pulse started", int'(prog_o), 1);
    if (mid_rst) bus_rst_i = 1'b1;  // R9: ignored during pulse
    @(negedge clk);
    bus_rst_i = 1'b0;
    repeat (PROG - 2) @(negedge clk);
    chk("R11 pulse still on", int'(prog_o), 1);
    @(negedge clk);
    vpp_i = 1'b0;
    chk("R11 pulse over", int'(prog_o), 0);
    for (int i = 0; i < SB; i++) exp_mem[seg*SB + i] = exp_mem[seg*SB + i] & d[i];
    for (int i = 0; i < SB; i++) take("R5 R6 verify", exp_mem[seg*SB + i]);
    chk("R6 verify end silent", int'(tx_vld_o), 0);
    bus_reset();
  endtask

  initial begin
    logic [7:0] d [SB];
    int seg, a;
    void'($urandom(32'h5EED_0042));
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; bus_rst_i = 1'b0; rx_vld_i = 1'b0; rx_byte_i = 8'h00;
    tx_rd_i = 1'b0; vpp_i = 1'b0;
    for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 reset no response", int'(tx_vld_o), 0);
    chk("R1 reset no pulse", int'(prog_o), 0);
    read_all("R1 erased");

    // random segment writes, some with a bus reset during the pulse
    for (int n = 0; n < 6; n++) begin
      seg = int'($urandom % (NB/SB));
      for (int i = 0; i < SB; i++) d[i] = 8'($urandom);
      write_seg(seg, d, n[0]);
    end
    // rewrite segment 3 twice so the AND is visible
    for (int i = 0; i < SB; i++) d[i] = 8'hF0 | 8'(i);
    write_seg(3, d, 1'b0);
    for (int i = 0; i < SB; i++) d[i] = 8'h3C;
    write_seg(3, d, 1'b1);
    // last segment edge
    for (int i = 0; i < SB; i++) d[i] = 8'(8'hA5 ^ 8'(i));
    write_seg(NB/SB - 1, d, 1'b0);
    read_all("R5 after writes");

    // R2: read from a random start to the end
    a = int'($urandom % NB);
    send(8'hF0); send(8'(a)); send(8'h00);
    take("R2 partial crc", crc3(8'hF0, 8'(a), 8'h00));
    for (int i = a; i < NB; i++) take("R2 partial data", exp_mem[i]);
    chk("R2 partial end", int'(tx_vld_o), 0);
    bus_reset();

    // R7: bad addresses and unknown command
    send(8'h0F); send(8'h0B); send(8'h00);
    chk("R7 unaligned silent", int'(tx_vld_o), 0);
    send(8'h00); send(8'h11);
    chk("R7 unaligned still silent", int'(tx_vld_o), 0);
    bus_reset();
    send(8'h0F); send(8'h00); send(8'h01);
    chk("R7 high byte silent", int'(tx_vld_o), 0);
    bus_reset();
    send(8'hF0); send(8'h80); send(8'h00);
    chk("R7 read range silent", int'(tx_vld_o), 0);
    bus_reset();
    send(8'h33); send(8'h00); send(8'h00);
    chk("R7 unknown cmd silent", int'(tx_vld_o), 0);
    bus_reset();

    // R8: wrong confirm byte
    for (int i = 0; i < SB; i++) d[i] = 8'h00;
    stage_seg(5, d);
    send(8'hA5);
    vpp_i = 1'b1;
    repeat (PROG + 4) @(negedge clk);
    chk("R8 no pulse", int'(prog_o), 0);
    chk("R8 silent", int'(tx_vld_o), 0);
    vpp_i = 1'b0;
    bus_reset();

    // R10: supply drops halfway
    stage_seg(6, d);
    send(8'h5A);
    vpp_i = 1'b1;
    @(negedge clk);
    chk("R10 pulse on", int'(prog_o), 1);
    repeat (PROG/2) @(negedge clk);
    vpp_i = 1'b0;
    @(negedge clk);
    chk("R10 pulse ended", int'(prog_o), 0);
    chk("R10 silent", int'(tx_vld_o), 0);
    bus_reset();

    // R9: bus reset while armed, before the pulse
    stage_seg(7, d);
    send(8'h5A);
    bus_reset();
    vpp_i = 1'b1;
    repeat (PROG + 4) @(negedge clk);
    chk("R9 armed reset no pulse", int'(prog_o), 0);
    vpp_i = 1'b0;

    // R9: abort during staging, then a clean write works
    send(8'h0F); send(8'h10); send(8'h00);
    take("R9 abort header crc", crc3(8'h0F, 8'h10, 8'h00));
    send(8'h00); send(8'h00); send(8'h00);
    bus_reset();
    chk("R9 abort silent", int'(tx_vld_o), 0);
    for (int i = 0; i < SB; i++) d[i] = 8'($urandom);
    write_seg(2, d, 1'b0);

    read_all("R7 R8 R10 final");

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule